// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This controller sits between a simple request port and the pins of a parallel NOR flash. A host hands it one request at a time: program one word, erase one sector, or erase one block. The controller then drives the unlock and command write cycles that the flash expects, with address setup, write pulse width and data hold all counted in clock ticks. After that it polls the status word at the target address until the flash reports that it has finished.

Completion is detected from the toggling status bit: the flash flips bit 6 on every status read while it is busy. Two reads in a row that return the same bit 6 mean the operation has ended. A timeout counter starts when the last command write ends. If it runs out before the status settles, the controller reports an error. Either way the controller goes back to idle and reports through a one-cycle response pulse.

The program timeout is held to a floor of 10 µs, worked out from the clock frequency parameter. The erase timeout is a separate parameter.

Top module: `nor_pe_sequencer`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Once a request is taken, `req_ready` drops, and `req_valid` has no effect until the response has been given.
- R2: `req_op` = 2'b00 (program) drives four write cycles, as (address, data): (0x5555, 0x00AA), (0x2AAA, 0x0055), (0x5555, 0x00A0), then (`req_addr`, `req_data`).
- R3: `req_op` = 2'b01 (sector erase) drives six write cycles: (0x5555, 0x00AA), (0x2AAA, 0x0055), (0x5555, 0x0080), (0x5555, 0x00AA), (0x2AAA, 0x0055), then (`req_addr`, 0x0050).
- R4: `req_op` = 2'b10 (block erase) drives the same six cycles as R3, except that the last data word is 0x0030.
- R5: In every write cycle, `fl_ce_n` is low and `fl_addr` is valid for T_AS clocks before `fl_we_n` falls. `fl_we_n` then stays low for exactly T_WP clocks. `fl_dq_oe` stays high, with `fl_dq_out` unchanged, in the clock where `fl_we_n` rises.
- R6: `fl_we_n` and `fl_oe_n` are never low together, and `fl_dq_oe` is never high while `fl_oe_n` is low.
- R7: After the last command write and until the response, the controller makes only status reads. `fl_we_n` stays high, and no further write cycle appears.
- R8: Completion is declared when two consecutive status reads return the same value on `fl_dq_in[6]`. A busy flash that toggles bit 6 on K reads in a row therefore gives K+2 reads, then `rsp_valid` with `rsp_err` = 0.
- R9: If the status has not settled within the timeout, `rsp_valid` is given with `rsp_err` = 1, and the response comes no earlier than the limit. The limit counts clocks from the end of the last write cycle. For program it is the larger of PROG_TMO_CYC and 10·CLK_MHZ; for erase it is ERASE_TMO_CYC. After the response the controller accepts requests again.
- R10: During and after reset, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, `fl_dq_oe` and `rsp_valid` are low, and `req_ready` is high. While idle, the flash bus stays quiet with all three strobes high.
- R11: `req_op` = 2'b11 is accepted and answered with `rsp_err` = 1 within three clocks, with no flash bus cycle at all.
- R12: `rsp_valid` is a single-clock pulse, and `req_ready` is high in the clock after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 2 | 00 program, 01 sector erase, 10 block erase, 11 reserved |
| req_addr | input | AW | Word, sector or block address |
| req_data | input | DW | Word to program |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_err | output | 1 | Response reports timeout or reserved operation |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Data driven to the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | DW | Data read from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
Some behaviours are checked by the assertions on every clock:
- the strobe rules: write and output enable are never low together, and the data bus is not driven during a read;
- the write pulse conditions: chip enable low and the address stable through the setup clock, and data still driven at the rising write edge;
- the quiet bus while idle;
- the absence of writes during polling;
- the single-clock response and the refusal of requests once one has been taken.

The other behaviours can only be shown by the bench scenarios:
- the exact address and data order of each command sequence;
- the write pulse width;
- the number of status reads as a function of how long the flash keeps toggling;
- the timeout distance, including the 10 µs floor applied to a short program setting;
- the handling of the reserved operation code.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_BLK  = 2'b10,
    OP_RSVD = 2'b11
  } op_e;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_POLL, S_RSP} seq_state_e;

  typedef enum logic [2:0] {B_IDLE, B_SET, B_ACT, B_HOLD, B_GAP} bus_ph_e;

  localparam logic [15:0] UNLK_A  = 16'h5555;
  localparam logic [15:0] UNLK_B  = 16'h2AAA;
  localparam logic [7:0]  C_KEY1  = 8'hAA;
  localparam logic [7:0]  C_KEY2  = 8'h55;
  localparam logic [7:0]  C_PROG  = 8'hA0;
  localparam logic [7:0]  C_ERASE = 8'h80;
  localparam logic [7:0]  C_SECT  = 8'h50;
  localparam logic [7:0]  C_BLK   = 8'h30;

  // number of write cycles in the command sequence of an operation
  function automatic logic [2:0] steps_for(op_e op);
    return (op == OP_PROG) ? 3'd4 : 3'd6;
  endfunction

  // unlock address used by a non-final step
  function automatic logic [15:0] step_unlock_addr(logic [2:0] idx);
    return (idx == 3'd1 || idx == 3'd4) ? UNLK_B : UNLK_A;
  endfunction

  // command byte of a step (a program's final step carries host data instead)
  function automatic logic [7:0] step_cmd(op_e op, logic [2:0] idx);
    case (idx)
      3'd0, 3'd3: return C_KEY1;
      3'd1, 3'd4: return C_KEY2;
      3'd2:       return (op == OP_PROG) ? C_PROG : C_ERASE;
      default:    return (op == OP_SECT) ? C_SECT : C_BLK;
    endcase
  endfunction

endpackage

// File: rtl/nps_bus_cycle.sv
module nps_bus_cycle
  import nps_pkg::*;
#(
  parameter int T_AS  = 1,
  parameter int T_WP  = 2,
  parameter int T_DH  = 1,
  parameter int T_RD  = 2,
  parameter int T_GAP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_wr,
  output logic idle,
  output logic sample,
  output logic done,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);
  localparam int TM1 = (T_AS > T_WP) ? T_AS : T_WP;
  localparam int TM2 = (T_DH > T_RD) ? T_DH : T_RD;
  localparam int TM3 = (TM1 > TM2) ? TM1 : TM2;
  localparam int TMX = (TM3 > T_GAP) ? TM3 : T_GAP;
  localparam int CW  = $clog2(TMX + 1);

  bus_ph_e       ph;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic          last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= B_IDLE;
      cnt  <= '0;
      wr_q <= 1'b0;
    end else if (ph == B_IDLE) begin
      if (start) begin
        ph   <= B_SET;
        cnt  <= CW'(T_AS - 1);
        wr_q <= is_wr;
      end
    end else if (!last) begin
      cnt <= cnt - 1'b1;
    end else begin
      case (ph)
        B_SET:  begin ph <= B_ACT;  cnt <= wr_q ? CW'(T_WP - 1) : CW'(T_RD - 1); end
        B_ACT:  begin ph <= B_HOLD; cnt <= CW'(T_DH - 1); end
        B_HOLD: begin ph <= B_GAP;  cnt <= CW'(T_GAP - 1); end
        default: ph <= B_IDLE;
      endcase
    end
  end

  assign idle   = (ph == B_IDLE);
  assign ce_n   = (ph == B_IDLE) || (ph == B_GAP);
  assign we_n   = !((ph == B_ACT) && wr_q);
  assign oe_n   = !((ph == B_ACT) && !wr_q);
  assign dq_oe  = wr_q && ((ph == B_SET) || (ph == B_ACT) || (ph == B_HOLD));
  assign sample = (ph == B_ACT) && !wr_q && last;
  assign done   = (ph == B_GAP) && last;
endmodule

// File: rtl/nps_toggle_mon.sv
module nps_toggle_mon #(
  parameter int DW       = 16,
  parameter int STAT_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sample,
  input  logic [DW-1:0] dq,
  output logic          settled
);
  logic prev_bit;
  logic have_prev;
  logic unused_dq;

  assign unused_dq = ^dq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_bit  <= 1'b0;
      have_prev <= 1'b0;
      settled   <= 1'b0;
    end else if (clear) begin
      have_prev <= 1'b0;
      settled   <= 1'b0;
    end else if (sample) begin
      settled   <= have_prev && (dq[STAT_BIT] == prev_bit);
      prev_bit  <= dq[STAT_BIT];
      have_prev <= 1'b1;
    end
  end
endmodule

// File: rtl/nps_timeout.sv
module nps_timeout #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= limit;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/nor_pe_sequencer.sv
module nor_pe_sequencer
  import nps_pkg::*;
#(
  parameter int AW            = 20,
  parameter int DW            = 16,
  parameter int T_AS          = 1,
  parameter int T_WP          = 2,
  parameter int T_DH          = 1,
  parameter int T_RD          = 2,
  parameter int T_GAP         = 1,
  parameter int CLK_MHZ       = 100,
  parameter int PROG_TMO_CYC  = 1000,
  parameter int ERASE_TMO_CYC = 2500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam int PROG_FLOOR = 10 * CLK_MHZ;
  localparam int PROG_LIMIT = (PROG_TMO_CYC > PROG_FLOOR) ? PROG_TMO_CYC : PROG_FLOOR;
  localparam int TMO_MAX    = (PROG_LIMIT > ERASE_TMO_CYC) ? PROG_LIMIT : ERASE_TMO_CYC;
  localparam int TW         = $clog2(TMO_MAX + 1);

  seq_state_e    state;
  op_e           op_q;
  logic [AW-1:0] tgt_addr, addr_q;
  logic [DW-1:0] tgt_data, dout_q;
  logic [2:0]    idx;
  logic          err_q;

  // named internal events
  logic accept, step_last, cyc_start, cyc_wr, load_tmo, in_poll;
  logic bus_idle, bus_sample, bus_done, settled, tmo_expired;
  logic [TW-1:0] tmo_limit;

  assign accept    = req_valid && (state == S_IDLE);
  assign step_last = (idx == 3'(steps_for(op_q) - 3'd1));
  assign in_poll   = (state == S_POLL);
  assign cyc_wr    = (state == S_WR);
  assign cyc_start = bus_idle && (cyc_wr || (in_poll && !tmo_expired));
  assign load_tmo  = cyc_wr && bus_done && step_last;
  assign tmo_limit = (op_q == OP_PROG) ? TW'(PROG_LIMIT) : TW'(ERASE_TMO_CYC);

  nps_bus_cycle #(
    .T_AS(T_AS), .T_WP(T_WP), .T_DH(T_DH), .T_RD(T_RD), .T_GAP(T_GAP)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .is_wr(cyc_wr),
    .idle(bus_idle), .sample(bus_sample), .done(bus_done),
    .ce_n(fl_ce_n), .we_n(fl_we_n), .oe_n(fl_oe_n), .dq_oe(fl_dq_oe)
  );

  nps_toggle_mon #(.DW(DW), .STAT_BIT(6)) u_tog (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(bus_sample),
    .dq(fl_dq_in), .settled(settled)
  );

  nps_timeout #(.TW(TW)) u_tmo (
    .clk(clk), .rst_n(rst_n), .load(load_tmo), .limit(tmo_limit),
    .expired(tmo_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= OP_PROG;
      tgt_addr <= '0;
      tgt_data <= '0;
      addr_q   <= '0;
      dout_q   <= '0;
      idx      <= '0;
      err_q    <= 1'b0;
    end else begin
      if (cyc_start) begin
        if (cyc_wr) begin
          addr_q <= step_last ? tgt_addr : AW'(step_unlock_addr(idx));
          dout_q <= (step_last && op_q == OP_PROG) ? tgt_data : DW'(step_cmd(op_q, idx));
        end else begin
          addr_q <= tgt_addr;
        end
      end
      case (state)
        S_IDLE: if (accept) begin
          op_q     <= op_e'(req_op);
          tgt_addr <= req_addr;
          tgt_data <= req_data;
          idx      <= '0;
          err_q    <= (op_e'(req_op) == OP_RSVD);
          state    <= (op_e'(req_op) == OP_RSVD) ? S_RSP : S_WR;
        end
        S_WR: if (bus_done) begin
          if (step_last) state <= S_POLL;
          else           idx   <= idx + 3'd1;
        end
        S_POLL: begin
          if (bus_done && settled) begin
            err_q <= 1'b0;
            state <= S_RSP;
          end else if (bus_idle && tmo_expired) begin
            err_q <= 1'b1;
            state <= S_RSP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RSP);
  assign rsp_err   = err_q;
  assign fl_addr   = addr_q;
  assign fl_dq_out = dout_q;
endmodule

// File: rtl/nps_checker.sv
module nps_checker #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dq_out,
  input logic          fl_dq_oe,
  input logic          fl_ce_n,
  input logic          fl_we_n,
  input logic          fl_oe_n,
  input logic          in_poll
);
  assert_taken_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_we_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> (!$past(fl_ce_n) && $stable(fl_addr) && !fl_ce_n));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (fl_dq_oe && $stable(fl_dq_out) && !fl_ce_n));

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  assert_no_drive_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);

  assert_poll_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_poll |-> (fl_we_n && !fl_dq_oe));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe));

  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
endmodule

bind nor_pe_sequencer nps_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
  .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
  .fl_oe_n(fl_oe_n), .in_poll(in_poll)
);

// File: tb/nor_pe_sequencer_tb_top.sv
module nor_pe_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int T_WP = 2;
  localparam int CLK_MHZ = 10;
  localparam int PROG_TMO = 40;    // below the 10 us floor: floor of 100 clocks applies
  localparam int ERASE_TMO = 300;
  localparam int PROG_LIM = 100;
  localparam int NV = 5;
  // {op[1:0], addr[19:0], data[15:0], toggles[7:0]}
  localparam logic [45:0] VECS [NV] = '{
    {2'd0, 20'h01234, 16'hBEEF, 8'd0},
    {2'd0, 20'hFFFFF, 16'h0000, 8'd3},
    {2'd1, 20'h0A800, 16'h1111, 8'd5},
    {2'd2, 20'h78000, 16'h2222, 8'd1},
    {2'd0, 20'h00000, 16'hFFFF, 8'd10}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, rsp_valid, rsp_err;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0, fl_addr;
  logic [DW-1:0] req_data = '0, fl_dq_out, fl_dq_in;
  logic fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  int checks = 0, fails = 0;
  int cyc = 0, cap_n = 0, rd_n = 0, last_rise = 0, we_run = 0, tog_left = 0;
  logic tog = 1'b0, prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1, setup_bad = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [AW-1:0] cap_addr [8];
  logic [DW-1:0] cap_data [8];
  int cap_run [8];
  logic cap_oe [8];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign fl_dq_in = {9'd0, tog, 6'd0};

  nor_pe_sequencer #(
    .AW(AW), .DW(DW), .T_AS(1), .T_WP(T_WP), .T_DH(1), .T_RD(2), .T_GAP(1),
    .CLK_MHZ(CLK_MHZ), .PROG_TMO_CYC(PROG_TMO), .ERASE_TMO_CYC(ERASE_TMO)
  ) dut_i (.*);

  // flash model and bus monitor
  always @(negedge clk) begin
    cyc++;
    if (!fl_we_n) we_run++;
    if (prev_we && !fl_we_n && !(!prev_ce && prev_addr == fl_addr)) setup_bad = 1'b1;
    if (!prev_we && fl_we_n) begin
      if (cap_n < 8) begin
        cap_addr[cap_n] = fl_addr; cap_data[cap_n] = fl_dq_out;
        cap_run[cap_n] = we_run;   cap_oe[cap_n] = fl_dq_oe;
      end
      cap_n++; we_run = 0; last_rise = cyc;
    end
    if (prev_oe && !fl_oe_n) rd_n++;
    if (!prev_oe && fl_oe_n && tog_left > 0) begin tog = ~tog; tog_left--; end
    prev_we = fl_we_n; prev_oe = fl_oe_n; prev_ce = fl_ce_n; prev_addr = fl_addr;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] e_addr(int op, int i, logic [19:0] t);
    if (i == ((op == 0) ? 3 : 5)) return t;
    return (i == 1 || i == 4) ? 20'h02AAA : 20'h05555;
  endfunction

  function automatic logic [15:0] e_data(int op, int i, logic [15:0] d);
    if (op == 0 && i == 3) return d;
    case (i)
      0, 3:    return 16'h00AA;
      1, 4:    return 16'h0055;
      2:       return (op == 0) ? 16'h00A0 : 16'h0080;
      default: return (op == 1) ? 16'h0050 : 16'h0030;
    endcase
  endfunction

  // issue one request and wait for its response; returns error flag and response cycle
  task automatic issue(input int op, input logic [19:0] a, input logic [15:0] d,
                       input int toggles, input bit poke, output bit err, output int rcyc);
    int n;
    cap_n = 0; rd_n = 0; setup_bad = 1'b0; we_run = 0;
    tog_left = toggles;
    n = 0;
    while (!req_ready && n < 5000) begin @(posedge clk); #2; n++; end
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
    @(posedge clk); #2;
    req_valid = 1'b0;
    if (poke) begin
      @(posedge clk); #2;
      check(req_ready == 1'b0, "R1 ready while busy", longint'(req_ready), 0);
      req_valid = 1'b1; req_op = 2'd2; req_addr = 20'h11111;
      repeat (3) begin @(posedge clk); #2; end
      req_valid = 1'b0;
    end
    n = 0;
    while (!rsp_valid && n < 5000) begin @(posedge clk); #2; n++; end
    err = rsp_err; rcyc = cyc;
    @(posedge clk); #2;
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R12 single pulse then ready",
          longint'({rsp_valid, req_ready}), 1);
  endtask

  task automatic check_seq(input int op, input logic [19:0] a, input logic [15:0] d);
    int n;
    string tag;
    n = (op == 0) ? 4 : 6;
    tag = (op == 0) ? "R2" : (op == 1) ? "R3" : "R4";
    check(cap_n == n, {tag, "/R7 write count"}, cap_n, n);
    for (int i = 0; i < n && i < 8; i++) begin
      check(cap_addr[i] == e_addr(op, i, a), {tag, " address"}, cap_addr[i], e_addr(op, i, a));
      check(cap_data[i] == e_data(op, i, d), {tag, " data"}, cap_data[i], e_data(op, i, d));
      check(cap_run[i] == T_WP && cap_oe[i], "R5 pulse width and data hold",
            cap_run[i], T_WP);
    end
    check(!setup_bad, "R5 setup with CE low and address stable", longint'(setup_bad), 0);
  endtask

  bit done_flag = 1'b0;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    bit e;
    int rc;
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    check(req_ready && fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !rsp_valid,
          "R10 reset state", longint'({req_ready, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, rsp_valid}),
          6'b111100);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check(req_ready && fl_ce_n && fl_we_n && fl_oe_n, "R10 idle after reset",
          longint'({req_ready, fl_ce_n, fl_we_n, fl_oe_n}), 4'hF);

    // table of sequences (R2, R3, R4, R8)
    for (int v = 0; v < NV; v++) begin
      int op, tg;
      op = int'(VECS[v][45:44]);
      tg = int'(VECS[v][7:0]);
      issue(op, VECS[v][43:24], VECS[v][23:8], tg, 1'b0, e, rc);
      check_seq(op, VECS[v][43:24], VECS[v][23:8]);
      check(e == 1'b0, "R8 completes without error", longint'(e), 0);
      check(rd_n == tg + 2, "R8 status read count", rd_n, tg + 2);
    end

    // R1: requests during a busy operation are refused
    issue(1, 20'h04000, 16'h0, 2, 1'b1, e, rc);
    check_seq(1, 20'h04000, 16'h0);
    check(e == 1'b0 && rd_n == 4, "R1 busy request ignored", rd_n, 4);

    // R9: program timeout with the 10 us floor
    issue(0, 20'h00321, 16'hA5A5, 255, 1'b0, e, rc);
    check(e == 1'b1, "R9 program timeout error", longint'(e), 1);
    check(rc - last_rise >= PROG_LIM && rc - last_rise <= PROG_LIM + 12,
          "R9 program timeout distance", rc - last_rise, PROG_LIM);
    check(cap_n == 4, "R7 no write while polling", cap_n, 4);

    // R9: erase timeout
    issue(2, 20'h40000, 16'h0, 255, 1'b0, e, rc);
    check(e == 1'b1, "R9 erase timeout error", longint'(e), 1);
    check(rc - last_rise >= ERASE_TMO && rc - last_rise <= ERASE_TMO + 12,
          "R9 erase timeout distance", rc - last_rise, ERASE_TMO);

    // R9: back to service after a timeout
    tog = 1'b0;
    issue(0, 20'h0ABCD, 16'h1234, 0, 1'b0, e, rc);
    check_seq(0, 20'h0ABCD, 16'h1234);
    check(e == 1'b0 && rd_n == 2, "R9 recovery after timeout", rd_n, 2);

    // R11: reserved op code
    begin
      int t0;
      t0 = cyc;
      issue(3, 20'h00001, 16'h0, 0, 1'b0, e, rc);
      check(e == 1'b1, "R11 reserved op error", longint'(e), 1);
      check(cap_n == 0 && rd_n == 0, "R11 no bus cycle", cap_n + rd_n, 0);
      check(rc - t0 <= 3, "R11 fast response", rc - t0, 3);
    end

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule